// File: doc/BRIEF.md
# Processing-Engine Receive Interface

This block sits between one router output port and the local processing engine of a tile. Flits arrive from the router and are buffered in a small queue. Each flit is handed to one of two lane assemblers, picked by its lane bit. Each lane tracks its own packet. The first flit of a packet is a routing header and is discarded. The second flit carries control fields for the engine: run enable, a new program-counter start value with its qualifier, sleep, wake, the payload kind, and a start address for memory writes. The payload flits after it are packed into memory words. A data packet fills 64-bit data-memory words from two payload flits each. An instruction packet fills 96-bit instruction-memory words from three payload flits each. The write address starts at the control flit's address field and steps by one for each word.

Local register-file stores own the data-memory write port. A received flit that would complete a data word stays at the head of the queue while a store is active, and flits behind it pile up. The router sees an almost-full flag early enough to stop sending. When the last data word of a packet is written while the engine is waiting for data, the block pulses a break output so the engine resumes.

Flit layout (38 bits): [31:0] payload, [32] lane, [33] first flit of packet, [34] last flit of packet, [37:35] spare. Control-flit payload: [0] run enable, [1] load new PC, [2] sleep, [3] wake, [4] kind (1 = instruction, 0 = data), [15:8] PC start value, [31:16] memory start address.

Top module: `pe_netif`

## Requirements
- R1: The queue holds up to 16 flits and delivers them in arrival order, with none lost while the almost-full rule is respected.
- R2: `almost_full_o` is high exactly when 2 or fewer of the 16 queue entries are free.
- R3: Flits of the two lanes may interleave flit by flit. Each lane assembles its own packet. At most one of data write, instruction write and PC load happens in any cycle.
- R4: A data packet writes one 64-bit word per two payload flits. The earlier flit goes to bits [31:0]. The first word goes to the control flit's address bits [31:16], and each later word to the next address.
- R5: An instruction packet writes one 96-bit word per three payload flits. The earliest flit goes to bits [31:0] and the last to bits [95:64]. The address comes from the same field as in R4 and also steps by one.
- R6: No data-memory write from the network occurs in the cycle after one in which `rf_store_i` was high. The held data is written once the store ends.
- R7: Each control flit sets `run_o` to its bit 0. When its bit 1 is set, `pc_load_o` pulses for one cycle with `pc_start_o` equal to bits [15:8]. When bit 1 is clear, there is no pulse.
- R8: A control flit with bit 2 set raises `sleep_o`, and one with bit 3 set clears it. When both bits are set, the engine ends up awake.
- R9: `brk_o` pulses together with the write of the final word of a data packet (the word whose last payload flit carries the last-flit bit) if `wfd_i` was high when that flit left the queue. Otherwise it stays low.
- R10: After reset every write, pulse and control output is low and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flit_valid_i | input | 1 | A flit is presented this cycle |
| flit_i | input | 38 | Incoming flit |
| almost_full_o | output | 1 | Queue has 2 or fewer free entries |
| rf_store_i | input | 1 | Register-file store owns data memory this cycle |
| wfd_i | input | 1 | Engine is stalled waiting for data |
| dmem_we_o | output | 1 | Data-memory write strobe |
| dmem_addr_o | output | 10 | Data-memory word address |
| dmem_wdata_o | output | 64 | Data-memory word |
| imem_we_o | output | 1 | Instruction-memory write strobe |
| imem_addr_o | output | 10 | Instruction-memory word address |
| imem_wdata_o | output | 96 | Instruction-memory word |
| run_o | output | 1 | Run enable for the engine |
| pc_load_o | output | 1 | One-cycle pulse: load program counter |
| pc_start_o | output | 8 | Program-counter start value |
| sleep_o | output | 1 | Engine sleep request |
| brk_o | output | 1 | One-cycle pulse releasing a wait-for-data stall |

## Verification
The collision that matters is a local register-file store meeting a received flit that would complete a data-memory word in the same cycle. The bench holds `rf_store_i` high while a data packet arrives. It then checks that no write appears, that the queue fills until the almost-full flag rises at exactly 14 held flits, and that every word comes out in order, at the right address, once the store ends. The second overlap is a sleep and a wake request in one control flit; the bench judges it by reading `sleep_o` after that flit, which must show the engine awake.

// File: rtl/nif_pkg.sv
// Shared flit layout and control-field positions for the receive interface.
// Assumes a single lane bit, i.e. two lanes.
package nif_pkg;
    localparam int DATA_W  = 32;
    localparam int LANE_W  = 1;
    localparam int NLANES  = 2 ** LANE_W;
    localparam int FLIT_W  = DATA_W + LANE_W + 2 + 3;

    typedef struct packed {
        logic [2:0]        spare;
        logic              last;
        logic              first;
        logic [LANE_W-1:0] lane;
        logic [DATA_W-1:0] data;
    } flit_t;

    // control flit payload fields
    localparam int CF_RUN   = 0;
    localparam int CF_NPC   = 1;
    localparam int CF_SLEEP = 2;
    localparam int CF_WAKE  = 3;
    localparam int CF_KIND  = 4;
    localparam int CF_PC_LSB   = 8;
    localparam int CF_ADDR_LSB = 16;
    localparam int CF_ADDR_W   = 16;
endpackage

// File: rtl/nif_rxq.sv
// Receive queue: a circular buffer of DEPTH flits with an occupancy count.
// Assumes DEPTH is a power of two; a push into a full queue is dropped.
module nif_rxq #(
    parameter int W     = 38,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [W-1:0]  din_i,
    input  logic          pop_i,
    output logic [W-1:0]  dout_o,
    output logic          empty_o,
    output logic [CW-1:0] cnt_o
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign do_push = push_i && (cnt_q != CW'(DEPTH));
    assign do_pop  = pop_i && (cnt_q != '0);
    assign dout_o  = mem[rd_q];
    assign empty_o = (cnt_q == '0);
    assign cnt_o   = cnt_q;

    // storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din_i;
    end

    // pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (do_pop)  rd_q <= rd_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/nif_lane.sv
// Per-lane packet assembler. Classifies the presented flit against the lane's
// packet state and, when take_i is high, consumes it. Assumes flits of one
// packet reach this lane in order; a first-flit always restarts the packet.
module nif_lane
    import nif_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  flit_t                flit_i,
    input  logic                 take_i,
    output logic                 is_ctrl_o,
    output logic                 word_done_o,
    output logic                 instr_o,
    output logic [CF_ADDR_W-1:0] addr_o,
    output logic [3*DATA_W-1:0]  word_o
);
    typedef enum logic [1:0] {L_IDLE, L_CTRL, L_PAY} lst_e;

    lst_e                  st_q;
    logic                  instr_q;
    logic [CF_ADDR_W-1:0]  addr_q;
    logic [1:0]            beat_q;
    logic [2*DATA_W-1:0]   buf_q;
    logic                  payload;
    logic [1:0]            last_beat;
    logic                  unused_lane;

    assign unused_lane = ^{flit_i.spare, flit_i.lane};

    // classify the presented flit
    always_comb begin
        is_ctrl_o   = (st_q == L_CTRL) && !flit_i.first;
        payload     = (st_q == L_PAY) && !flit_i.first;
        last_beat   = instr_q ? 2'd2 : 2'd1;
        word_done_o = payload && (beat_q == last_beat);
        instr_o     = instr_q;
        addr_o      = addr_q;
        word_o      = instr_q ? {flit_i.data, buf_q}
                              : {{DATA_W{1'b0}}, flit_i.data, buf_q[DATA_W-1:0]};
    end

    // packet state, framing buffer and address counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= L_IDLE;
            instr_q <= 1'b0;
            addr_q  <= '0;
            beat_q  <= '0;
            buf_q   <= '0;
        end else if (take_i) begin
            if (flit_i.first) begin
                st_q <= flit_i.last ? L_IDLE : L_CTRL;
            end else if (is_ctrl_o) begin
                instr_q <= flit_i.data[CF_KIND];
                addr_q  <= flit_i.data[CF_ADDR_LSB +: CF_ADDR_W];
                beat_q  <= '0;
                st_q    <= flit_i.last ? L_IDLE : L_PAY;
            end else if (payload) begin
                if (word_done_o) begin
                    beat_q <= '0;
                    addr_q <= addr_q + 1'b1;
                end else begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q[0]) buf_q[2*DATA_W-1:DATA_W] <= flit_i.data;
                    else           buf_q[DATA_W-1:0]        <= flit_i.data;
                end
                if (flit_i.last) st_q <= L_IDLE;
            end
        end
    end
endmodule

// File: rtl/nif_ctl.sv
// Engine control decoder: turns each control flit into run, PC-load and
// sleep state. Wake wins over sleep when both bits are set.
module nif_ctl
    import nif_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              run_o,
    output logic              pc_load_o,
    output logic [PC_W-1:0]   pc_start_o,
    output logic              sleep_o
);
    logic unused_bits;
    assign unused_bits = ^{word_i[DATA_W-1:CF_PC_LSB+PC_W], word_i[CF_PC_LSB-1:CF_KIND]};

    // decode control fields on a consumed control flit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o      <= 1'b0;
            pc_load_o  <= 1'b0;
            pc_start_o <= '0;
            sleep_o    <= 1'b0;
        end else if (fire_i) begin
            run_o     <= word_i[CF_RUN];
            pc_load_o <= word_i[CF_NPC];
            if (word_i[CF_NPC]) pc_start_o <= word_i[CF_PC_LSB +: PC_W];
            if (word_i[CF_WAKE])       sleep_o <= 1'b0;
            else if (word_i[CF_SLEEP]) sleep_o <= 1'b1;
        end else begin
            pc_load_o <= 1'b0;
        end
    end
endmodule

// File: rtl/pe_netif.sv
// Receive-side network interface of a processing engine. Queues flits, steers
// each to its lane assembler, writes framed words to data or instruction
// memory, yields data writes to local stores, and drives engine control.
// Assumes at most one flit per cycle from the router, which honours
// almost_full_o with enough slack for its in-flight flits.
module pe_netif
    import nif_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int AF_FREE = 2,
    parameter int DADDR_W = 10,
    parameter int IADDR_W = 10,
    parameter int PC_W    = 8,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flit_valid_i,
    input  logic [FLIT_W-1:0]    flit_i,
    output logic                 almost_full_o,
    input  logic                 rf_store_i,
    input  logic                 wfd_i,
    output logic                 dmem_we_o,
    output logic [DADDR_W-1:0]   dmem_addr_o,
    output logic [2*DATA_W-1:0]  dmem_wdata_o,
    output logic                 imem_we_o,
    output logic [IADDR_W-1:0]   imem_addr_o,
    output logic [3*DATA_W-1:0]  imem_wdata_o,
    output logic                 run_o,
    output logic                 pc_load_o,
    output logic [PC_W-1:0]      pc_start_o,
    output logic                 sleep_o,
    output logic                 brk_o
);
    logic [FLIT_W-1:0]    q_dout;
    logic                 q_empty;
    logic [CW-1:0]        q_cnt;
    flit_t                head;
    logic                 pop, stall, ctrl_fire;
    logic                 sel_ctrl, sel_done, sel_instr;
    logic [CF_ADDR_W-1:0] sel_addr;
    logic [3*DATA_W-1:0]  sel_word;

    logic                 lane_ctrl  [NLANES];
    logic                 lane_done  [NLANES];
    logic                 lane_instr [NLANES];
    logic [CF_ADDR_W-1:0] lane_addr  [NLANES];
    logic [3*DATA_W-1:0]  lane_word  [NLANES];
    logic                 unused_hi;

    nif_rxq #(.W(FLIT_W), .DEPTH(DEPTH)) u_q (
        .clk(clk), .rst_n(rst_n),
        .push_i(flit_valid_i), .din_i(flit_i),
        .pop_i(pop), .dout_o(q_dout), .empty_o(q_empty), .cnt_o(q_cnt)
    );

    assign head          = flit_t'(q_dout);
    assign almost_full_o = (q_cnt >= CW'(DEPTH - AF_FREE));

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic take;
        assign take = pop && (int'(head.lane) == g);
        nif_lane u_lane (
            .clk(clk), .rst_n(rst_n), .flit_i(head), .take_i(take),
            .is_ctrl_o(lane_ctrl[g]), .word_done_o(lane_done[g]),
            .instr_o(lane_instr[g]), .addr_o(lane_addr[g]), .word_o(lane_word[g])
        );
    end

    // pick the lane addressed by the head flit, and decide whether it may leave
    always_comb begin
        sel_ctrl  = lane_ctrl[head.lane];
        sel_done  = lane_done[head.lane];
        sel_instr = lane_instr[head.lane];
        sel_addr  = lane_addr[head.lane];
        sel_word  = lane_word[head.lane];
        stall     = rf_store_i && sel_done && !sel_instr;
        pop       = !q_empty && !stall;
        ctrl_fire = pop && sel_ctrl;
    end

    assign unused_hi = ^{sel_addr[CF_ADDR_W-1:(DADDR_W < IADDR_W ? DADDR_W : IADDR_W)]};

    // registered memory write ports and break pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dmem_we_o    <= 1'b0;
            dmem_addr_o  <= '0;
            dmem_wdata_o <= '0;
            imem_we_o    <= 1'b0;
            imem_addr_o  <= '0;
            imem_wdata_o <= '0;
            brk_o        <= 1'b0;
        end else begin
            dmem_we_o <= pop && sel_done && !sel_instr;
            imem_we_o <= pop && sel_done && sel_instr;
            brk_o     <= pop && sel_done && !sel_instr && head.last && wfd_i;
            if (pop && sel_done && !sel_instr) begin
                dmem_addr_o  <= sel_addr[DADDR_W-1:0];
                dmem_wdata_o <= sel_word[2*DATA_W-1:0];
            end
            if (pop && sel_done && sel_instr) begin
                imem_addr_o  <= sel_addr[IADDR_W-1:0];
                imem_wdata_o <= sel_word;
            end
        end
    end

    nif_ctl #(.PC_W(PC_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .fire_i(ctrl_fire), .word_i(head.data),
        .run_o(run_o), .pc_load_o(pc_load_o), .pc_start_o(pc_start_o),
        .sleep_o(sleep_o)
    );
endmodule

// File: rtl/nif_chk.sv
// Property checker for pe_netif, attached by bind. Observes queue occupancy
// and the output strobes; drives nothing.
module nif_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rf_store_i,
    input logic [CW-1:0] q_cnt,
    input logic          dmem_we_o,
    input logic          imem_we_o,
    input logic          pc_load_o,
    input logic          brk_o
);
    // R1
    q_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt <= CW'(DEPTH));

    // R3
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dmem_we_o, imem_we_o, pc_load_o}));

    // R6
    store_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we_o |-> !$past(rf_store_i));

    // R9
    brk_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |-> dmem_we_o);
endmodule

bind pe_netif nif_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rf_store_i(rf_store_i), .q_cnt(q_cnt),
    .dmem_we_o(dmem_we_o), .imem_we_o(imem_we_o),
    .pc_load_o(pc_load_o), .brk_o(brk_o)
);

// File: tb/tb_pe_netif.sv
module tb_pe_netif;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flit_valid_i = 1'b0;
    logic [37:0]  flit_i = '0;
    logic         almost_full_o;
    logic         rf_store_i = 1'b0;
    logic         wfd_i = 1'b0;
    logic         dmem_we_o;
    logic [9:0]   dmem_addr_o;
    logic [63:0]  dmem_wdata_o;
    logic         imem_we_o;
    logic [9:0]   imem_addr_o;
    logic [95:0]  imem_wdata_o;
    logic         run_o, pc_load_o, sleep_o, brk_o;
    logic [7:0]   pc_start_o;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pe_netif dut (.*);

    // write logs, filled by the monitor only
    int          dn = 0, in = 0;
    logic [9:0]  d_addr [64];
    logic [63:0] d_data [64];
    logic        d_brk  [64];
    logic [9:0]  i_addr [16];
    logic [95:0] i_data [16];

    always @(negedge clk) begin
        if (dmem_we_o && dn < 64) begin
            d_addr[dn] = dmem_addr_o; d_data[dn] = dmem_wdata_o; d_brk[dn] = brk_o;
            dn = dn + 1;
        end
        if (imem_we_o && in < 16) begin
            i_addr[in] = imem_addr_o; i_data[in] = imem_wdata_o;
            in = in + 1;
        end
    end

    function automatic logic [37:0] mk(input logic ln, input logic fst,
                                       input logic lst, input logic [31:0] d);
        return {3'b000, lst, fst, ln, d};
    endfunction

    task automatic chk(input logic ok, input string tag,
                       input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [37:0] f);
        flit_valid_i = 1'b1;
        flit_i = f;
        @(negedge clk);
        flit_valid_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // control-flit vectors: payload, then expected {run, pc_load, sleep, pc}
    localparam logic [31:0] VEC_CTRL [0:5] = '{
        32'h0000_3C03, 32'h0000_0004, 32'h0000_000C,
        32'h0000_0005, 32'h0000_0008, 32'h0000_A503
    };
    localparam logic [10:0] VEC_EXP [0:5] = '{
        {3'b110, 8'h3C}, {3'b001, 8'h00}, {3'b000, 8'h00},
        {3'b101, 8'h00}, {3'b000, 8'h00}, {3'b110, 8'hA5}
    };

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(!dmem_we_o && !imem_we_o && !pc_load_o && !brk_o, "R10 strobes", 
            {dmem_we_o, imem_we_o, pc_load_o, brk_o}, 0);
        chk(!run_o && !sleep_o && !almost_full_o, "R10 levels",
            {run_o, sleep_o, almost_full_o}, 0);

        // R7 R8 control decoding table
        for (int k = 0; k < 6; k++) begin
            send(mk(1'b0, 1'b1, 1'b0, 32'h0));
            send(mk(1'b0, 1'b0, 1'b1, VEC_CTRL[k]));
            idle(1);
            chk(run_o == VEC_EXP[k][10], "R7 run", run_o, VEC_EXP[k][10]);
            chk(pc_load_o == VEC_EXP[k][9], "R7 pc_load", pc_load_o, VEC_EXP[k][9]);
            if (VEC_EXP[k][9])
                chk(pc_start_o == VEC_EXP[k][7:0], "R7 pc_start", pc_start_o, VEC_EXP[k][7:0]);
            chk(sleep_o == VEC_EXP[k][8], "R8 sleep", sleep_o, VEC_EXP[k][8]);
            idle(1);
        end

        // R4 R9 two-word data packet with the engine waiting
        wfd_i = 1'b1;
        base = dn;
        send(mk(1'b0, 1'b1, 1'b0, 32'h0));
        send(mk(1'b0, 1'b0, 1'b0, 32'h0010_0000));
        send(mk(1'b0, 1'b0, 1'b0, 32'h1111_1111));
        send(mk(1'b0, 1'b0, 1'b0, 32'h2222_2222));
        send(mk(1'b0, 1'b0, 1'b0, 32'h3333_3333));
        send(mk(1'b0, 1'b0, 1'b1, 32'h4444_4444));
        idle(3);
        chk(dn - base == 2, "R4 word count", dn - base, 2);
        chk(d_addr[base] == 10'h010 && d_data[base] == 64'h2222_2222_1111_1111,
            "R4 word0", {d_addr[base], d_data[base]}, {10'h010, 64'h2222_2222_1111_1111});
        chk(d_addr[base+1] == 10'h011 && d_data[base+1] == 64'h4444_4444_3333_3333,
            "R4 word1", {d_addr[base+1], d_data[base+1]}, {10'h011, 64'h4444_4444_3333_3333});
        chk(!d_brk[base] && d_brk[base+1], "R9 break on final word",
            {d_brk[base], d_brk[base+1]}, 2'b01);

        // R9 no break when the engine is not waiting
        wfd_i = 1'b0;
        base = dn;
        send(mk(1'b0, 1'b1, 1'b0, 32'h0));
        send(mk(1'b0, 1'b0, 1'b0, 32'h0040_0000));
        send(mk(1'b0, 1'b0, 1'b0, 32'h5555_0000));
        send(mk(1'b0, 1'b0, 1'b1, 32'h5555_0001));
        idle(3);
        chk(dn - base == 1 && !d_brk[base], "R9 no break without wait",
            {dn - base, d_brk[base]}, {32'd1, 1'b0});

        // R5 instruction packet on lane 1
        base = in;
        send(mk(1'b1, 1'b1, 1'b0, 32'h0));
        send(mk(1'b1, 1'b0, 1'b0, 32'h0020_0010));
        send(mk(1'b1, 1'b0, 1'b0, 32'hAAAA_AAAA));
        send(mk(1'b1, 1'b0, 1'b0, 32'hBBBB_BBBB));
        send(mk(1'b1, 1'b0, 1'b1, 32'hCCCC_CCCC));
        idle(3);
        chk(in - base == 1, "R5 word count", in - base, 1);
        chk(i_addr[base] == 10'h020 && i_data[base] == 96'hCCCC_CCCC_BBBB_BBBB_AAAA_AAAA,
            "R5 word", {i_addr[base], i_data[base]},
            {10'h020, 96'hCCCC_CCCC_BBBB_BBBB_AAAA_AAAA});

        // R3 lanes interleaved flit by flit
        base = dn;
        begin
            int ib;
            ib = in;
            send(mk(1'b0, 1'b1, 1'b0, 32'h0));
            send(mk(1'b1, 1'b1, 1'b0, 32'h0));
            send(mk(1'b0, 1'b0, 1'b0, 32'h0050_0000));
            send(mk(1'b1, 1'b0, 1'b0, 32'h0060_0010));
            send(mk(1'b0, 1'b0, 1'b0, 32'hD000_0000));
            send(mk(1'b1, 1'b0, 1'b0, 32'hE000_0000));
            send(mk(1'b0, 1'b0, 1'b1, 32'hD000_0001));
            send(mk(1'b1, 1'b0, 1'b0, 32'hE000_0001));
            send(mk(1'b1, 1'b0, 1'b1, 32'hE000_0002));
            idle(3);
            chk(dn - base == 1 && d_addr[base] == 10'h050 &&
                d_data[base] == 64'hD000_0001_D000_0000, "R3 lane0 data",
                {d_addr[base], d_data[base]}, {10'h050, 64'hD000_0001_D000_0000});
            chk(in - ib == 1 && i_addr[ib] == 10'h060 &&
                i_data[ib] == 96'hE000_0002_E000_0001_E000_0000, "R3 lane1 instr",
                {i_addr[ib], i_data[ib]}, {10'h060, 96'hE000_0002_E000_0001_E000_0000});
        end

        // R6 store holds a completed data word in the queue
        rf_store_i = 1'b1;
        base = dn;
        send(mk(1'b0, 1'b1, 1'b0, 32'h0));
        send(mk(1'b0, 1'b0, 1'b0, 32'h0070_0000));
        send(mk(1'b0, 1'b0, 1'b0, 32'h7700_0000));
        send(mk(1'b0, 1'b0, 1'b1, 32'h7700_0001));
        idle(5);
        chk(dn == base && !dmem_we_o, "R6 no write during store", dn - base, 0);
        rf_store_i = 1'b0;
        idle(2);
        chk(dn - base == 1 && d_addr[base] == 10'h070 &&
            d_data[base] == 64'h7700_0001_7700_0000, "R6 write after store",
            {d_addr[base], d_data[base]}, {10'h070, 64'h7700_0001_7700_0000});

        // R1 R2 backlog behind a store: flag at 14 held flits, nothing lost
        rf_store_i = 1'b1;
        base = dn;
        send(mk(1'b0, 1'b1, 1'b0, 32'h0));
        send(mk(1'b0, 1'b0, 1'b0, 32'h0080_0000));
        for (int k = 0; k < 14; k++)
            send(mk(1'b0, 1'b0, 1'b0, 32'hF000_0000 + k));
        chk(!almost_full_o, "R2 clear at 13 held", almost_full_o, 0);
        send(mk(1'b0, 1'b0, 1'b0, 32'hF000_000E));
        chk(almost_full_o, "R2 set at 14 held", almost_full_o, 1);
        send(mk(1'b0, 1'b0, 1'b1, 32'hF000_000F));
        chk(almost_full_o && dn == base, "R6 still held", {almost_full_o, dn - base}, {1'b1, 32'd0});
        rf_store_i = 1'b0;
        idle(20);
        chk(dn - base == 8, "R1 all words drained", dn - base, 8);
        chk(d_addr[base] == 10'h080 && d_data[base] == 64'hF000_0001_F000_0000,
            "R1 first word", {d_addr[base], d_data[base]}, {10'h080, 64'hF000_0001_F000_0000});
        chk(d_addr[base+7] == 10'h087 && d_data[base+7] == 64'hF000_000F_F000_000E,
            "R1 last word", {d_addr[base+7], d_data[base+7]}, {10'h087, 64'hF000_000F_F000_000E});
        chk(!almost_full_o, "R2 clear after drain", almost_full_o, 0);

        // R8 sleep and wake together after a sleep
        send(mk(1'b0, 1'b1, 1'b0, 32'h0));
        send(mk(1'b0, 1'b0, 1'b1, 32'h0000_0004));
        idle(1);
        chk(sleep_o, "R8 asleep", sleep_o, 1);
        send(mk(1'b0, 1'b1, 1'b0, 32'h0));
        send(mk(1'b0, 1'b0, 1'b1, 32'h0000_000C));
        idle(1);
        chk(!sleep_o, "R8 wake wins", sleep_o, 0);

        // R10 reset clears state
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        chk(!run_o && !sleep_o && !almost_full_o && !dmem_we_o, "R10 after reset",
            {run_o, sleep_o, almost_full_o, dmem_we_o}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule